// File: doc/BRIEF.md
# GPIO Controller with Edge Interrupts

This block is a 32-line general purpose I/O controller with a word-wide register interface. Software picks the direction of each line, drives output values, enables the sampling of inputs, and reads back a data word. Every line's input goes through a two-flop synchronizer. Changes on the synchronized value are detected as edges and latched into an event register. For each line a control bit chooses one of two edge senses: falling edges only, or both edges.

Events are recorded whether or not a line's interrupt is enabled. A single combined interrupt output is raised while any pending event has its mask bit set. Software clears an event by writing a 1 to its bit. Across all registers the bit order is reversed relative to the line number, so line 0 sits in the most significant bit. Register writes take effect on the clock edge that samples them. Register reads are combinational from the byte offset.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: Line n of `pin_in`, `pin_out` and `pin_oe` corresponds to register bit 31-n in every register. For example, writing 32'h8000_0000 to the data register sets `pin_out[0]`.
- R2: A 1 in the direction register (offset 0x00) makes the line an output, and `pin_oe` for that line is 1. A 0 makes it an input, and `pin_oe` is 0.
- R3: For an input line whose input-enable bit (offset 0x18) is 1, a data register read (offset 0x08) returns the pin value 3 clock edges after the pin changes. While the input-enable bit is 0, the data bit holds its previous value.
- R4: For an output line, the data register read returns the last value written to that bit of the data register, whatever the pin level.
- R5: Writing a 1 to a bit of the event register (offset 0x0C) clears that event on the write edge. Writing a 0 leaves the bit unchanged.
- R6: `irq` is 1 exactly when the bitwise AND of the event register and the mask register (offset 0x10, 1 = enabled) is nonzero. A mask change affects `irq` right after the write edge.
- R7: If a line's control bit (offset 0x14) is 1, only a falling edge sets its event. If the bit is 0, both rising and falling edges set it. The event becomes visible 3 clock edges after the pin change.
- R8: After reset, all six registers read 0, all lines are inputs, and `irq` is 0.
- R9: A read of any other offset (such as 0x04 or 0x1C) returns 0. A write to such an offset changes no register.
- R10: If an edge and a write-1-to-clear reach the same event bit on the same clock edge, the bit stays set.
- R11: An edge on a masked line still sets its event bit, and `irq` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Byte offset of the register accessed |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `addr` |
| pin_in | input | 32 | Line inputs, indexed by line number |
| pin_out | output | 32 | Output latch values, indexed by line number |
| pin_oe | output | 32 | Output enables, indexed by line number |
| irq | output | 1 | Combined interrupt |

## Verification
A register write is visible on `rd_data`, `pin_out`, `pin_oe` and `irq` once the write edge has passed. A pin change goes through two synchronizer flops and then one event or data flop, so it is visible after the third rising edge. The bench waits exactly those edges before it queues an expected value. The monitor compares each queued value one time unit after the next rising edge, while the address and the pins are held. The case of a clear colliding with an edge is timed by counting edges from the pin change, so that the clear write lands on the same edge as the event update.

// File: rtl/gpio_ctl_pkg.sv
package gpio_ctl_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam logic [ADDR_W-1:0] OFS_DIR  = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_DATA = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_EVT  = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_MASK = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 5'h14;
  localparam logic [ADDR_W-1:0] OFS_IBE  = 5'h18;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
      q_prev <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
      q_prev <= q;
    end
  end
endmodule

// File: rtl/gpio_evt.sv
module gpio_evt #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] prev,
  input  logic [W-1:0] fall_only,
  input  logic [W-1:0] clr,
  output logic [W-1:0] evt
);
  logic [W-1:0] rise, fall, hit, evt_nxt;

  always_comb begin
    rise    = cur & ~prev;
    fall    = ~cur & prev;
    hit     = fall | (rise & ~fall_only);
    evt_nxt = (evt & ~clr) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt <= '0;
    else        evt <= evt_nxt;
  end

  for (genvar i = 0; i < W; i++) begin : g_chk
    // R5: a clear with no edge empties the bit
    p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && (cur[i] == prev[i])) |=> !evt[i]);
    // R7: a rising edge is ignored in falling-only mode
    p_fall_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fall_only[i] && cur[i] && !prev[i] && !evt[i]) |=> !evt[i]);
    // R10: an edge wins over a simultaneous clear in both-edge mode
    p_edge_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && (cur[i] != prev[i]) && !fall_only[i]) |=> evt[i]);
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_ctl_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wr_data,
  input  logic [W-1:0]      smp,
  output logic [W-1:0]      dir,
  output logic [W-1:0]      out_lat,
  output logic [W-1:0]      mask,
  output logic [W-1:0]      ctrl,
  output logic [W-1:0]      ibe,
  output logic [W-1:0]      din,
  output logic [W-1:0]      evt_clr
);
  logic we_dir, we_data, we_mask, we_ctrl, we_ibe;
  logic [W-1:0] din_nxt;

  always_comb begin
    we_dir  = wr_en && (addr == OFS_DIR);
    we_data = wr_en && (addr == OFS_DATA);
    we_mask = wr_en && (addr == OFS_MASK);
    we_ctrl = wr_en && (addr == OFS_CTRL);
    we_ibe  = wr_en && (addr == OFS_IBE);
    evt_clr = (wr_en && (addr == OFS_EVT)) ? wr_data : '0;
    din_nxt = (smp & ibe) | (din & ~ibe);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir     <= '0;
      out_lat <= '0;
      mask    <= '0;
      ctrl    <= '0;
      ibe     <= '0;
      din     <= '0;
    end else begin
      if (we_dir)  dir     <= wr_data;
      if (we_data) out_lat <= wr_data;
      if (we_mask) mask    <= wr_data;
      if (we_ctrl) ctrl    <= wr_data;
      if (we_ibe)  ibe     <= wr_data;
      din <= din_nxt;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_chk
    // R3: a disabled input holds its sampled value
    p_ibe_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !ibe[i] |=> $stable(din[i]));
  end
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_ctl_pkg::*;
#(
  parameter int unsigned NLINE = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NLINE-1:0]  wr_data,
  output logic [NLINE-1:0]  rd_data,
  input  logic [NLINE-1:0]  pin_in,
  output logic [NLINE-1:0]  pin_out,
  output logic [NLINE-1:0]  pin_oe,
  output logic              irq
);
  localparam int unsigned TOP = NLINE - 1;

  logic [NLINE-1:0] pin_bits, smp, smp_prev;
  logic [NLINE-1:0] dir, out_lat, mask, ctrl, ibe, din, evt_clr, evt;
  logic [NLINE-1:0] data_rd;

  for (genvar n = 0; n < NLINE; n++) begin : g_map
    assign pin_bits[TOP-n] = pin_in[n];
    assign pin_out[n]      = out_lat[TOP-n];
    assign pin_oe[n]       = dir[TOP-n];
  end

  gpio_sync #(.W(NLINE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_bits), .q(smp), .q_prev(smp_prev)
  );

  gpio_regs #(.W(NLINE)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .smp(smp), .dir(dir), .out_lat(out_lat), .mask(mask), .ctrl(ctrl),
    .ibe(ibe), .din(din), .evt_clr(evt_clr)
  );

  gpio_evt #(.W(NLINE)) u_evt (
    .clk(clk), .rst_n(rst_n), .cur(smp), .prev(smp_prev),
    .fall_only(ctrl), .clr(evt_clr), .evt(evt)
  );

  always_comb begin
    data_rd = (out_lat & dir) | (din & ~dir);
    case (addr)
      OFS_DIR:  rd_data = dir;
      OFS_DATA: rd_data = data_rd;
      OFS_EVT:  rd_data = evt;
      OFS_MASK: rd_data = mask;
      OFS_CTRL: rd_data = ctrl;
      OFS_IBE:  rd_data = ibe;
      default:  rd_data = '0;
    endcase
    irq = |(evt & mask);
  end

  // R6: with every line masked the interrupt stays low
  p_irq_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq);
endmodule

// File: tb/gpio_edge_ctrl_test.sv
`timescale 1ns/1ps
module gpio_edge_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic        irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_edge_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .irq(irq)
  );

  function automatic logic [31:0] bl(input int n);
    return 32'h1 << (31 - n);
  endfunction

  // monitor: compares one queued item after each rising edge
  initial begin
    item_t it;
    logic [31:0] act;
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        it = sb.pop_front();
        case (it.kind)
          0: act = rd_data;
          1: act = {31'b0, irq};
          2: act = pin_oe;
          default: act = pin_out;
        endcase
        n_run++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: got %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk(input int kind, input logic [4:0] a, input logic [31:0] e,
                     input string tag);
    item_t it;
    @(negedge clk);
    addr = a;
    it.kind = kind; it.exp = e; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic pins(input logic [31:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8 reset state
    chk(0, 5'h00, 32'h0, "R8 dir");
    chk(0, 5'h08, 32'h0, "R8 data");
    chk(0, 5'h0C, 32'h0, "R8 evt");
    chk(0, 5'h10, 32'h0, "R8 mask");
    chk(0, 5'h14, 32'h0, "R8 ctrl");
    chk(0, 5'h18, 32'h0, "R8 ibe");
    chk(1, 5'h00, 32'h0, "R8 irq");
    chk(2, 5'h00, 32'h0, "R8 pin_oe");

    // R9 unmapped offsets
    wr(5'h04, 32'hFFFF_FFFF);
    wr(5'h1C, 32'hFFFF_FFFF);
    chk(0, 5'h04, 32'h0, "R9 read 0x04");
    chk(0, 5'h1C, 32'h0, "R9 read 0x1C");
    chk(0, 5'h00, 32'h0, "R9 dir untouched");
    chk(0, 5'h10, 32'h0, "R9 mask untouched");

    // R2 / R1 direction and bit reversal
    wr(5'h00, bl(0) | bl(5));
    chk(2, 5'h00, 32'h0000_0021, "R2 pin_oe lines 0,5");
    wr(5'h08, bl(0));
    chk(3, 5'h00, 32'h0000_0001, "R1 pin_out line 0");
    chk(0, 5'h08, bl(0), "R4 output readback");

    // R3 input blocked while input-enable is 0; R11 event while masked
    pins(32'h0000_0008);
    chk(0, 5'h08, bl(0), "R3 disabled input holds");
    chk(0, 5'h0C, bl(3), "R11 event while masked");
    chk(1, 5'h00, 32'h0, "R11 irq low while masked");
    wr(5'h18, 32'hFFFF_FFFF);
    chk(0, 5'h08, bl(0) | bl(3), "R3 enabled input visible");

    // R5 write-1-to-clear
    wr(5'h0C, 32'h0);
    chk(0, 5'h0C, bl(3), "R5 write 0 keeps event");
    wr(5'h0C, bl(3));
    chk(0, 5'h0C, 32'h0, "R5 write 1 clears event");

    // R6 combined interrupt
    wr(5'h10, bl(3));
    chk(1, 5'h00, 32'h0, "R6 no event no irq");
    pins(32'h0000_0000);
    chk(0, 5'h08, bl(0), "R3 input fall visible");
    chk(1, 5'h00, 32'h1, "R6 irq on unmasked event");
    wr(5'h10, 32'h0);
    chk(1, 5'h00, 32'h0, "R6 irq drops on mask");
    chk(0, 5'h0C, bl(3), "R6 event kept on mask");
    wr(5'h10, bl(3));
    chk(1, 5'h00, 32'h1, "R6 irq back on unmask");
    wr(5'h0C, bl(3));
    chk(1, 5'h00, 32'h0, "R6 irq drops on clear");

    // R7 edge sense
    wr(5'h14, bl(7));
    pins(32'h0000_0080);
    chk(0, 5'h0C, 32'h0, "R7 rise ignored fall-only");
    pins(32'h0000_0000);
    chk(0, 5'h0C, bl(7), "R7 fall sets fall-only");
    wr(5'h0C, bl(7));
    wr(5'h14, 32'h0);
    pins(32'h0000_0080);
    chk(0, 5'h0C, bl(7), "R7 rise sets both-edge");
    wr(5'h0C, bl(7));

    // R10 edge and clear on the same edge
    pins(32'h0000_0280);
    chk(0, 5'h0C, bl(9), "R10 setup event");
    @(negedge clk);
    pin_in = 32'h0000_0080;
    @(negedge clk);
    @(negedge clk);
    addr = 5'h0C; wr_data = bl(9); wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    chk(0, 5'h0C, bl(9), "R10 edge wins over clear");
    wr(5'h0C, bl(9));
    chk(0, 5'h0C, 32'h0, "R10 clear without edge");

    // R1 multi-line data pattern
    pins(32'h8000_0081);
    chk(0, 5'h08, 32'h8100_0001, "R1 data bit reversal");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule